// File: doc/BRIEF.md
# Dual-Controller Interrupt Priority Arbiter

This block merges the pending requests of two interrupt controllers into one winning request for the processor. Each controller owns a bank of sources. Every source carries a pending bit, a mask bit, a programmed level from 1 to 7, a priority within that level, and an 8-bit vector number. The block compares level first and priority second across both banks. It uses the fixed order of the controllers only when the two best candidates are equal in both level and priority.

An acknowledge selector picks what the acknowledge read returns. The value zero gives the software acknowledge, which is the vector of the overall winner. The values 1 through 7 give the level acknowledge, which is the best source inside that one level. All selection logic is combinational. The winning level, the winning vector and the acknowledge data are each captured once per clock.

Top module: `irq_arb`

## Requirements
- R1: While `rstN` is low, `winLevel`, `winVec` and `ackData` are all 0.
- R2: A source takes part in no comparison, for the winner or for any acknowledge, if its mask bit is 1, its pending bit is 0, or its level is 0.
- R3: Among the qualifying sources of both controllers, the source with the numerically highest level wins, whichever controller it belongs to.
- R4: When the best candidates are at equal level, the one with the numerically larger priority value wins, even if it belongs to controller 1.
- R5: When the best candidate of controller 0 and the best candidate of controller 1 have identical level and priority, controller 0 wins.
- R6: Inside one controller, when two sources are equal in level and priority, the one with the lower source index wins.
- R7: `winLevel` and `winVec` show the winner for the inputs present at the previous rising clock edge. When no source qualifies, `winLevel` is 0 and `winVec` is 0x18.
- R8: With `ackSel` = 0 at a rising edge, `ackData` after that edge equals the vector of the overall winner.
- R9: With `ackSel` = n, where n is 1 to 7, at a rising edge, `ackData` after that edge is the vector of the best qualifying source whose level is exactly n. The rules of R4, R5 and R6 apply inside that level.
- R10: When no source qualifies for the selected acknowledge, `ackData` is the spurious vector 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| c0Pend | input | NumSrc | Controller 0 pending bits |
| c0Mask | input | NumSrc | Controller 0 mask bits (1 = masked) |
| c0Level | input | NumSrc x 3 | Controller 0 level per source (0 = no request) |
| c0Prio | input | NumSrc x 3 | Controller 0 priority per source (larger wins) |
| c0Vec | input | NumSrc x 8 | Controller 0 vector per source |
| c1Pend | input | NumSrc | Controller 1 pending bits |
| c1Mask | input | NumSrc | Controller 1 mask bits (1 = masked) |
| c1Level | input | NumSrc x 3 | Controller 1 level per source |
| c1Prio | input | NumSrc x 3 | Controller 1 priority per source |
| c1Vec | input | NumSrc x 8 | Controller 1 vector per source |
| ackSel | input | 3 | 0 = software acknowledge, 1 to 7 = acknowledge of that level |
| winLevel | output | 3 | Registered winning level (0 = none) |
| winVec | output | 8 | Registered winning vector |
| ackData | output | 8 | Registered acknowledge read data |

## Verification
Every output is one register stage away from the comparison logic. A wrong comparison or a wrong tie rule therefore shows up on the ports one clock after the stimulus that triggers it. A wrong order between the controllers appears only when the two best candidates are exactly equal, so the tests build those ties on purpose. A faulty level filter leaves `winVec` correct and shows only as a wrong or non-spurious `ackData` for a level that is empty.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  parameter int LvlW = 3;
  parameter int PriW = 3;
  parameter int VecW = 8;
  parameter int NumCtl = 2;

  typedef struct packed {
    logic            valid;
    logic [LvlW-1:0] level;
    logic [PriW-1:0] prio;
    logic [VecW-1:0] vec;
  } cand_t;

  typedef struct packed {
    logic            swAck;
    logic [LvlW-1:0] lvlSel;
  } ack_strb_t;

  function automatic logic beats(cand_t a, cand_t b);
    return a.valid && (!b.valid || a.level > b.level ||
                       (a.level == b.level && a.prio > b.prio));
  endfunction
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic [LvlW-1:0] ackSel,
  output ack_strb_t       strb
);
  always_comb begin
    strb.swAck  = (ackSel == '0);
    strb.lvlSel = ackSel;
  end
endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
#(
  parameter int NumSrc = 8
) (
  input  logic [NumSrc-1:0]           pend,
  input  logic [NumSrc-1:0]           mask,
  input  logic [NumSrc-1:0][LvlW-1:0] level,
  input  logic [NumSrc-1:0][PriW-1:0] prio,
  input  logic [NumSrc-1:0][VecW-1:0] vec,
  input  logic                        filtEn,
  input  logic [LvlW-1:0]             filtLvl,
  output cand_t                       best
);
  always_comb begin
    best = '0;
    for (int i = 0; i < NumSrc; i++) begin
      if (pend[i] && !mask[i] && level[i] != '0 &&
          (!filtEn || level[i] == filtLvl) &&
          beats('{valid: 1'b1, level: level[i], prio: prio[i], vec: vec[i]}, best)) begin
        best = '{valid: 1'b1, level: level[i], prio: prio[i], vec: vec[i]};
      end
    end
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int             NumSrc  = 8,
  parameter logic [VecW-1:0] SpurVec = 8'h18
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [NumCtl-1:0][NumSrc-1:0]           pend,
  input  logic [NumCtl-1:0][NumSrc-1:0]           mask,
  input  logic [NumCtl-1:0][NumSrc-1:0][LvlW-1:0] level,
  input  logic [NumCtl-1:0][NumSrc-1:0][PriW-1:0] prio,
  input  logic [NumCtl-1:0][NumSrc-1:0][VecW-1:0] vec,
  input  ack_strb_t                               strb,
  output logic [LvlW-1:0]                         winLevel,
  output logic [VecW-1:0]                         winVec,
  output logic [VecW-1:0]                         ackData
);
  cand_t winCand [NumCtl];
  cand_t lvlCand [NumCtl];
  cand_t winBest, lvlBest, ackBest;

  for (genvar g = 0; g < NumCtl; g++) begin : g_ctl
    irq_arb_pick #(.NumSrc(NumSrc)) uWin (
      .pend(pend[g]), .mask(mask[g]), .level(level[g]), .prio(prio[g]),
      .vec(vec[g]), .filtEn(1'b0), .filtLvl('0), .best(winCand[g]));
    irq_arb_pick #(.NumSrc(NumSrc)) uLvl (
      .pend(pend[g]), .mask(mask[g]), .level(level[g]), .prio(prio[g]),
      .vec(vec[g]), .filtEn(1'b1), .filtLvl(strb.lvlSel), .best(lvlCand[g]));
  end

  // lower controller index keeps the grant unless strictly beaten
  always_comb begin
    winBest = winCand[0];
    lvlBest = lvlCand[0];
    for (int c = 1; c < NumCtl; c++) begin
      if (beats(winCand[c], winBest)) winBest = winCand[c];
      if (beats(lvlCand[c], lvlBest)) lvlBest = lvlCand[c];
    end
    ackBest = strb.swAck ? winBest : lvlBest;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winLevel <= '0;
      winVec   <= '0;
      ackData  <= '0;
    end else begin
      winLevel <= winBest.valid ? winBest.level : '0;
      winVec   <= winBest.valid ? winBest.vec   : SpurVec;
      ackData  <= ackBest.valid ? ackBest.vec   : SpurVec;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_arb_pkg::*;
#(
  parameter int NumSrc = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NumSrc-1:0]           c0Pend,
  input  logic [NumSrc-1:0]           c0Mask,
  input  logic [NumSrc-1:0][LvlW-1:0] c0Level,
  input  logic [NumSrc-1:0][PriW-1:0] c0Prio,
  input  logic [NumSrc-1:0][VecW-1:0] c0Vec,
  input  logic [NumSrc-1:0]           c1Pend,
  input  logic [NumSrc-1:0]           c1Mask,
  input  logic [NumSrc-1:0][LvlW-1:0] c1Level,
  input  logic [NumSrc-1:0][PriW-1:0] c1Prio,
  input  logic [NumSrc-1:0][VecW-1:0] c1Vec,
  input  logic [LvlW-1:0]             ackSel,
  output logic [LvlW-1:0]             winLevel,
  output logic [VecW-1:0]             winVec,
  output logic [VecW-1:0]             ackData
);
  ack_strb_t strb;

  irq_arb_ctrl uCtrl (.ackSel(ackSel), .strb(strb));

  irq_arb_dp #(.NumSrc(NumSrc)) uDp (
    .clk(clk), .rstN(rstN),
    .pend({c1Pend, c0Pend}), .mask({c1Mask, c0Mask}),
    .level({c1Level, c0Level}), .prio({c1Prio, c0Prio}),
    .vec({c1Vec, c0Vec}), .strb(strb),
    .winLevel(winLevel), .winVec(winVec), .ackData(ackData));
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int NumSrc = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NumSrc-1:0]           c0Pend,
  input logic [NumSrc-1:0]           c0Mask,
  input logic [NumSrc-1:0][LvlW-1:0] c0Level,
  input logic [NumSrc-1:0]           c1Pend,
  input logic [NumSrc-1:0]           c1Mask,
  input logic [NumSrc-1:0][LvlW-1:0] c1Level,
  input logic [LvlW-1:0]             ackSel,
  input logic [LvlW-1:0]             winLevel,
  input logic [VecW-1:0]             winVec,
  input logic [VecW-1:0]             ackData
);
  logic primed;
  logic [LvlW-1:0] topLvl, topLvlQ;
  logic [LvlW-1:0] selQ;

  always_comb begin
    topLvl = '0;
    for (int i = 0; i < NumSrc; i++) begin
      if (c0Pend[i] && !c0Mask[i] && c0Level[i] > topLvl) topLvl = c0Level[i];
      if (c1Pend[i] && !c1Mask[i] && c1Level[i] > topLvl) topLvl = c1Level[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed  <= 1'b0;
      topLvlQ <= '0;
      selQ    <= '0;
    end else begin
      primed  <= 1'b1;
      topLvlQ <= topLvl;
      selQ    <= ackSel;
    end
  end

  // R3
  top_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> winLevel == topLvlQ);

  // R2
  no_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && topLvlQ == '0) |-> winLevel == '0);

  // R7
  idle_spur_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && winLevel == '0) |-> winVec == 8'h18);

  // R8
  sw_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && selQ == '0) |-> ackData == winVec);
endmodule

bind irq_arb irq_arb_chk #(.NumSrc(NumSrc)) uChk (
  .clk(clk), .rstN(rstN),
  .c0Pend(c0Pend), .c0Mask(c0Mask), .c0Level(c0Level),
  .c1Pend(c1Pend), .c1Mask(c1Mask), .c1Level(c1Level),
  .ackSel(ackSel), .winLevel(winLevel), .winVec(winVec), .ackData(ackData));

// File: tb/irq_arb_test.sv
module irq_arb_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] c0Pend, c0Mask, c1Pend, c1Mask;
  logic [N-1:0][2:0] c0Level, c0Prio, c1Level, c1Prio;
  logic [N-1:0][7:0] c0Vec, c1Vec;
  logic [2:0] ackSel;
  logic [2:0] winLevel;
  logic [7:0] winVec, ackData;

  irq_arb #(.NumSrc(N)) uut (.*);

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    logic [2:0] lvl;
    logic [7:0] vec;
    logic [7:0] ack;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  // monitor: compares registered outputs once their cycle has come
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "winLevel", int'(winLevel), int'(e.lvl));
      check(e.tag, "winVec",   int'(winVec),   int'(e.vec));
      check(e.tag, "ackData",  int'(ackData),  int'(e.ack));
    end
  end

  task automatic clearAll();
    c0Pend = '0; c0Mask = '0; c0Level = '0; c0Prio = '0; c0Vec = '0;
    c1Pend = '0; c1Mask = '0; c1Level = '0; c1Prio = '0; c1Vec = '0;
    ackSel = '0;
  endtask

  task automatic setSrc(int ctl, int idx, int lvl, int pri, int vec, bit msk);
    if (ctl == 0) begin
      c0Pend[idx] = 1'b1; c0Mask[idx] = msk; c0Level[idx] = 3'(lvl);
      c0Prio[idx] = 3'(pri); c0Vec[idx] = 8'(vec);
    end else begin
      c1Pend[idx] = 1'b1; c1Mask[idx] = msk; c1Level[idx] = 3'(lvl);
      c1Prio[idx] = 3'(pri); c1Vec[idx] = 8'(vec);
    end
  endtask

  // driver: called at a falling edge with sources set
  task automatic apply(int sel, int eLvl, int eVec, int eAck, string tag);
    exp_t e;
    ackSel = 3'(sel);
    e.due = cyc + 1; e.lvl = 3'(eLvl); e.vec = 8'(eVec); e.ack = 8'(eAck); e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    clearAll();
  endtask

  initial begin
    clearAll();
    repeat (3) @(negedge clk);
    check("R1", "winLevel", int'(winLevel), 0);
    check("R1", "winVec",   int'(winVec),   0);
    check("R1", "ackData",  int'(ackData),  0);
    rstN = 1'b1;

    apply(0, 0, 8'h18, 8'h18, "R7_R10_idle");

    setSrc(0, 2, 5, 3, 8'h42, 0); setSrc(1, 1, 5, 3, 8'h81, 0);
    apply(0, 5, 8'h42, 8'h42, "R5_R8_tie");

    setSrc(0, 0, 4, 7, 8'h40, 0); setSrc(1, 3, 6, 0, 8'h90, 0);
    apply(0, 6, 8'h90, 8'h90, "R3_level_win");

    setSrc(0, 1, 3, 2, 8'h30, 0); setSrc(1, 5, 3, 5, 8'h55, 0);
    apply(0, 3, 8'h55, 8'h55, "R4_prio_win");

    setSrc(0, 0, 2, 1, 8'h21, 0); setSrc(1, 0, 7, 7, 8'h77, 1);
    apply(0, 2, 8'h21, 8'h21, "R2_masked");

    setSrc(1, 4, 0, 7, 8'h99, 0); setSrc(0, 6, 1, 0, 8'h11, 0);
    apply(0, 1, 8'h11, 8'h11, "R2_level0");

    setSrc(1, 2, 4, 4, 8'hA2, 0); setSrc(1, 6, 4, 4, 8'hA6, 0);
    apply(0, 4, 8'hA2, 8'hA2, "R6_index_tie");

    setSrc(0, 0, 3, 1, 8'h31, 0); setSrc(0, 1, 3, 6, 8'h36, 0); setSrc(1, 0, 6, 2, 8'h62, 0);
    apply(3, 6, 8'h62, 8'h36, "R9_level3");

    setSrc(0, 0, 3, 1, 8'h31, 0); setSrc(1, 7, 3, 4, 8'hB4, 0); setSrc(1, 1, 6, 2, 8'h62, 0);
    apply(3, 6, 8'h62, 8'hB4, "R9_level3_ctl1");

    setSrc(0, 0, 3, 1, 8'h31, 0); setSrc(0, 1, 3, 6, 8'h36, 0); setSrc(1, 0, 6, 2, 8'h62, 0);
    apply(2, 6, 8'h62, 8'h18, "R10_empty_level");

    setSrc(0, 0, 5, 3, 8'h51, 1); setSrc(1, 2, 5, 0, 8'h50, 0);
    apply(5, 5, 8'h50, 8'h50, "R2_R9_masked_level");

    setSrc(0, 7, 7, 1, 8'h70, 0); setSrc(1, 0, 7, 1, 8'h71, 0);
    apply(7, 7, 8'h70, 8'h70, "R5_R9_level7_tie");

    setSrc(0, 3, 2, 5, 8'h25, 0);
    apply(6, 2, 8'h25, 8'h18, "R10_above_winner");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule